// File: doc/BRIEF.md
# Scatter-Gather Descriptor DMA Engine

The engine copies memory regions as directed by a chain of descriptors that also live in memory. Software places descriptors back to back, then pulses `start` with the address of the first one. The engine reads each descriptor, which is a source pointer, a destination pointer and a control word. It then copies the described region one 32-bit word at a time. Each word is read from the source and written to the destination. After that it moves on to the next descriptor, until it finishes one marked as last.

Descriptor fetches and data traffic share one word-wide memory port. That port takes a request, holds it, and waits for an acknowledge that may carry an error flag. Words travel unchanged, so little-endian byte order in memory is preserved.

Progress and faults collect in a five-bit sticky status word, which software clears by writing ones. A level interrupt shows a completed chain.

Top module: `sgdma_engine`

## Requirements
- R1: After reset `status` is 0, and `irq`, `busy` and `mem_req` are low.
- R2: A descriptor is three consecutive words at base, base+4 and base+8, in this order: source address, destination address, control word. Control bits 17:0 are the byte count and bit 31 is the last flag. Bits 30:18 have no effect.
- R3: For a descriptor with byte count N, the engine copies N/4 words in ascending address order. Each word is a read from the source followed by a write to the destination, with the value unchanged. Words just past the region are not written.
- R4: When a descriptor without the last flag completes, the engine fetches the next descriptor 12 bytes higher. The walk ends after the descriptor with the last flag.
- R5: When the final word of a last descriptor is read, status bit 0 (read done) is set. When that word is written, status bit 1 (write done) is set and the engine goes idle. `irq` is high exactly while bit 1 is set.
- R6: Status bit 4 (array error) is set, the engine halts, and bit 1 stays clear in any of these cases: a start base not a multiple of 4, an error response to a descriptor fetch, a zero byte count, or a source, destination or byte count not a multiple of 4. No data word of that descriptor is written.
- R7: An error response to a data read sets status bit 2 and halts the engine before that word is written.
- R8: An error response to a data write sets status bit 3 and halts the engine, and bit 1 stays clear.
- R9: Status bits are sticky. A cycle with `clr` high clears exactly the bits set in `clr_mask`. If the hardware sets a bit in the same cycle that software clears it, the set wins.
- R10: A `start` pulse while `busy` is high has no effect on the walk in progress.
- R11: Once `mem_req` is raised, it stays high with `mem_addr`, `mem_we` and `mem_wdata` unchanged until a cycle with `mem_ack`. Every address is word aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that begins a walk |
| start_base | input | 32 | Address of the first descriptor, sampled with `start` |
| clr | input | 1 | Write-one-to-clear strobe for status |
| clr_mask | input | 5 | Status bits to clear when `clr` is high |
| status | output | 5 | Bit 0 read done, 1 write done, 2 read error, 3 write error, 4 array error |
| busy | output | 1 | High while a walk is in progress |
| irq | output | 1 | Level interrupt, mirrors write done |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address of the request |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request accepted, read data valid |
| mem_rdata | input | 32 | Read data |
| mem_err | input | 1 | Error response qualifying `mem_ack` |

## Verification
Software clearing a status bit can land in the same cycle as the hardware setting that bit at the end of a chain. The bench provokes this by holding `clr` high with every mask bit set for a whole walk. The set must win. Sampled between edges, write done must then be visible for exactly one cycle, `irq` must pulse along with it, and status must be all zero afterwards. A second overlap, a new `start` arriving while a walk is running, is judged by the copied data and the write count of the first chain, which must be unchanged.

// File: rtl/sgdma_pkg.sv
package sgdma_pkg;

  localparam int SB_RD_DONE = 0;
  localparam int SB_WR_DONE = 1;
  localparam int SB_RD_ERR  = 2;
  localparam int SB_WR_ERR  = 3;
  localparam int SB_ARR_ERR = 4;
  localparam int STAT_W     = 5;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_F0,
    ST_F1,
    ST_F2,
    ST_CHK,
    ST_RD,
    ST_WR
  } sg_state_e;

  // A descriptor is unusable when it moves nothing or is not word aligned.
  function automatic logic desc_bad(input logic [31:0] src,
                                    input logic [31:0] dst,
                                    input logic [31:0] len);
    return (len == 32'd0) || (src[1:0] != 2'b00) ||
           (dst[1:0] != 2'b00) || (len[1:0] != 2'b00);
  endfunction

  function automatic logic [31:0] next_desc(input logic [31:0] cur);
    return cur + 32'd12;
  endfunction

  function automatic logic [31:0] word_addr(input logic [31:0] base,
                                            input logic [1:0]  idx);
    return base + {28'd0, idx, 2'b00};
  endfunction

endpackage

// File: rtl/sgdma_desc_regs.sv
module sgdma_desc_regs #(
  parameter int LEN_W    = 18,
  parameter int LAST_BIT = 31
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_en,
  input  logic [1:0]       cap_idx,
  input  logic [31:0]      cap_word,
  output logic [31:0]      d_src,
  output logic [31:0]      d_dst,
  output logic [LEN_W-1:0] d_len,
  output logic             d_last,
  output logic             d_bad
);
  import sgdma_pkg::*;

  localparam int NWORDS = 3;

  logic [31:0] words [NWORDS];

  for (genvar i = 0; i < NWORDS; i++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        words[i] <= '0;
      else if (cap_en && (cap_idx == i[1:0]))
        words[i] <= cap_word;
    end
  end

  assign d_src  = words[0];
  assign d_dst  = words[1];
  assign d_len  = words[2][LEN_W-1:0];
  assign d_last = words[2][LAST_BIT];
  assign d_bad  = desc_bad(d_src, d_dst, {{(32-LEN_W){1'b0}}, d_len});

endmodule

// File: rtl/sgdma_mover.sv
module sgdma_mover #(
  parameter int LEN_W = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [31:0]      src_in,
  input  logic [31:0]      dst_in,
  input  logic [LEN_W-1:0] len_in,
  input  logic             step,
  input  logic             data_cap,
  input  logic [31:0]      data_in,
  output logic [31:0]      src_ptr,
  output logic [31:0]      dst_ptr,
  output logic [31:0]      data_q,
  output logic             final_word
);
  localparam int CNT_W = LEN_W - 2;

  logic [CNT_W-1:0] words_left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_ptr    <= '0;
      dst_ptr    <= '0;
      words_left <= '0;
    end else if (load) begin
      src_ptr    <= src_in;
      dst_ptr    <= dst_in;
      words_left <= len_in[LEN_W-1:2];
    end else if (step) begin
      src_ptr    <= src_ptr + 32'd4;
      dst_ptr    <= dst_ptr + 32'd4;
      words_left <= words_left - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      data_q <= '0;
    else if (data_cap)
      data_q <= data_in;
  end

  assign final_word = (words_left == {{(CNT_W-1){1'b0}}, 1'b1});

endmodule

// File: rtl/sgdma_status.sv
module sgdma_status #(
  parameter int SW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] set_vec,
  input  logic          clr,
  input  logic [SW-1:0] clr_mask,
  output logic [SW-1:0] status,
  output logic          irq
);
  import sgdma_pkg::*;

  logic [SW-1:0] clr_eff;
  assign clr_eff = clr ? clr_mask : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      status <= '0;
    else
      status <= (status & ~clr_eff) | set_vec;
  end

  assign irq = status[SB_WR_DONE];

  // R9
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((status & $past(status)) == $past(status)));

  // R9
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_vec) |=> ((status & $past(set_vec)) == $past(set_vec)));

endmodule

// File: rtl/sgdma_engine.sv
module sgdma_engine #(
  parameter int LEN_W    = 18,
  parameter int LAST_BIT = 31
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [31:0] start_base,
  input  logic        clr,
  input  logic [4:0]  clr_mask,
  output logic [4:0]  status,
  output logic        busy,
  output logic        irq,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata,
  input  logic        mem_err
);
  import sgdma_pkg::*;

  sg_state_e          st, st_nxt;
  logic [31:0]        desc_ptr;
  logic               ptr_load, ptr_adv;
  logic               cap_en;
  logic [1:0]         cap_idx;
  logic               mv_load, mv_step, data_cap;
  logic [STAT_W-1:0]  set_vec;
  logic [31:0]        d_src, d_dst;
  logic [LEN_W-1:0]   d_len;
  logic               d_last, d_bad;
  logic [31:0]        src_ptr, dst_ptr, data_q;
  logic               final_word;
  logic               err_halt;

  sgdma_desc_regs #(.LEN_W(LEN_W), .LAST_BIT(LAST_BIT)) u_desc (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .cap_idx(cap_idx),
    .cap_word(mem_rdata), .d_src(d_src), .d_dst(d_dst), .d_len(d_len),
    .d_last(d_last), .d_bad(d_bad)
  );

  sgdma_mover #(.LEN_W(LEN_W)) u_mover (
    .clk(clk), .rst_n(rst_n), .load(mv_load), .src_in(d_src),
    .dst_in(d_dst), .len_in(d_len), .step(mv_step), .data_cap(data_cap),
    .data_in(mem_rdata), .src_ptr(src_ptr), .dst_ptr(dst_ptr),
    .data_q(data_q), .final_word(final_word)
  );

  sgdma_status #(.SW(STAT_W)) u_status (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr(clr),
    .clr_mask(clr_mask), .status(status), .irq(irq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      desc_ptr <= '0;
    end else begin
      st <= st_nxt;
      if (ptr_load)
        desc_ptr <= start_base;
      else if (ptr_adv)
        desc_ptr <= next_desc(desc_ptr);
    end
  end

  always_comb begin
    st_nxt    = st;
    set_vec   = '0;
    cap_en    = 1'b0;
    cap_idx   = 2'd0;
    mv_load   = 1'b0;
    mv_step   = 1'b0;
    data_cap  = 1'b0;
    ptr_load  = 1'b0;
    ptr_adv   = 1'b0;
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = data_q;
    unique case (st)
      ST_IDLE: begin
        if (start) begin
          if (start_base[1:0] != 2'b00) begin
            set_vec[SB_ARR_ERR] = 1'b1;
          end else begin
            ptr_load = 1'b1;
            st_nxt   = ST_F0;
          end
        end
      end
      ST_F0, ST_F1, ST_F2: begin
        cap_idx  = (st == ST_F0) ? 2'd0 : (st == ST_F1) ? 2'd1 : 2'd2;
        mem_req  = 1'b1;
        mem_addr = word_addr(desc_ptr, cap_idx);
        if (mem_ack) begin
          if (mem_err) begin
            set_vec[SB_ARR_ERR] = 1'b1;
            st_nxt = ST_IDLE;
          end else begin
            cap_en = 1'b1;
            st_nxt = (st == ST_F0) ? ST_F1 : (st == ST_F1) ? ST_F2 : ST_CHK;
          end
        end
      end
      ST_CHK: begin
        if (d_bad) begin
          set_vec[SB_ARR_ERR] = 1'b1;
          st_nxt = ST_IDLE;
        end else begin
          mv_load = 1'b1;
          st_nxt  = ST_RD;
        end
      end
      ST_RD: begin
        mem_req  = 1'b1;
        mem_addr = src_ptr;
        if (mem_ack) begin
          if (mem_err) begin
            set_vec[SB_RD_ERR] = 1'b1;
            st_nxt = ST_IDLE;
          end else begin
            data_cap = 1'b1;
            if (final_word && d_last)
              set_vec[SB_RD_DONE] = 1'b1;
            st_nxt = ST_WR;
          end
        end
      end
      ST_WR: begin
        mem_req  = 1'b1;
        mem_we   = 1'b1;
        mem_addr = dst_ptr;
        if (mem_ack) begin
          if (mem_err) begin
            set_vec[SB_WR_ERR] = 1'b1;
            st_nxt = ST_IDLE;
          end else begin
            mv_step = 1'b1;
            if (final_word) begin
              if (d_last) begin
                set_vec[SB_WR_DONE] = 1'b1;
                st_nxt = ST_IDLE;
              end else begin
                ptr_adv = 1'b1;
                st_nxt  = ST_F0;
              end
            end else begin
              st_nxt = ST_RD;
            end
          end
        end
      end
      default: st_nxt = ST_IDLE;
    endcase
  end

  assign busy     = (st != ST_IDLE);
  assign err_halt = set_vec[SB_ARR_ERR] | set_vec[SB_RD_ERR] | set_vec[SB_WR_ERR];

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) &&
                               $stable(mem_we) && $stable(mem_wdata)));

  // R11
  addr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[1:0] == 2'b00));

  // R6
  err_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_halt |=> (!busy && !irq));

  // R5
  done_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_vec[SB_WR_DONE] |-> (d_last && final_word));

  // R10
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !ptr_adv) |=> (desc_ptr == $past(desc_ptr)));

endmodule

// File: tb/sgdma_engine_test.sv
`timescale 1ns/1ps
module sgdma_engine_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] start_base = '0;
  logic        clr = 1'b0;
  logic [4:0]  clr_mask = '0;
  logic [4:0]  status;
  logic        busy, irq;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        mem_err = 1'b0;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int wr_count = 0;

  logic [31:0] mem [0:255];
  logic        err_on = 1'b0;
  logic [31:0] err_addr = '0;
  logic        err_we = 1'b0;

  always #4 clk = ~clk;

  sgdma_engine uut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_base(start_base),
    .clr(clr), .clr_mask(clr_mask), .status(status), .busy(busy), .irq(irq),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .mem_err(mem_err)
  );

  // Memory model: answers one cycle after a request is seen.
  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (mem_req && !mem_ack) begin
      mem_ack   <= 1'b1;
      mem_rdata <= mem[mem_addr[9:2]];
      mem_err   <= err_on && (mem_addr == err_addr) && (mem_we == err_we);
      if (mem_we && !(err_on && (mem_addr == err_addr) && err_we)) begin
        mem[mem_addr[9:2]] <= mem_wdata;
        wr_count <= wr_count + 1;
      end
    end else begin
      mem_ack <= 1'b0;
      mem_err <= 1'b0;
    end
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    wait (cycles > 150000);
    errors++;
    $display("FAIL watchdog: actual=%0d cycles expected=<150000", cycles);
    finish_run();
  end

  task automatic check(input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic put_desc(input logic [31:0] a, input logic [31:0] s,
                          input logic [31:0] d, input logic [31:0] c);
    mem[a[9:2]]       = s;
    mem[a[9:2] + 8'd1] = d;
    mem[a[9:2] + 8'd2] = c;
  endtask

  task automatic prep();
    @(negedge clk);
    clr = 1'b1; clr_mask = 5'h1F;
    @(negedge clk);
    clr = 1'b0; clr_mask = 5'h00;
    err_on = 1'b0;
    for (int i = 0; i < 256; i++) mem[i] = 32'hDEAD_0000 | i;
    wr_count = 0;
  endtask

  task automatic kick(input logic [31:0] base);
    @(negedge clk);
    start = 1'b1; start_base = base;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 4000; i++) begin
      if (!busy) break;
      @(negedge clk);
    end
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 status", {27'd0, status}, 32'h0);
    check("R1 irq/busy/req", {29'd0, irq, busy, mem_req}, 32'h0);
  endtask

  task automatic t_single();
    prep();
    // reserved bits 30:18 all set, last flag, 16 bytes
    put_desc(32'h100, 32'h200, 32'h300, 32'hFFFC_0010);
    kick(32'h100);
    wait_idle();
    for (int i = 0; i < 4; i++)
      check("R3 copied word", mem[8'hC0 + i], 32'hDEAD_0080 + i);
    check("R3 past region untouched", mem[8'hC4], 32'hDEAD_00C4);
    check("R2 reserved ignored, word count", wr_count, 32'd4);
    check("R5 status done", {27'd0, status}, 32'h3);
    check("R5 irq high", {31'd0, irq}, 32'h1);
    @(negedge clk); clr = 1'b1; clr_mask = 5'b00010;
    @(negedge clk); clr = 1'b0;
    check("R9 masked clear", {27'd0, status}, 32'h1);
    check("R5 irq follows bit1", {31'd0, irq}, 32'h0);
  endtask

  task automatic t_chain();
    prep();
    put_desc(32'h040, 32'h200, 32'h380, 32'h0000_0008);
    put_desc(32'h04C, 32'h210, 32'h3C0, 32'h8000_0004);
    put_desc(32'h3F0, 32'h200, 32'h000, 32'h8000_0040);
    kick(32'h040);
    @(negedge clk);
    start = 1'b1; start_base = 32'h3F0;
    @(negedge clk);
    start = 1'b0;
    wait_idle();
    check("R4 first desc w0", mem[8'hE0], 32'hDEAD_0080);
    check("R4 first desc w1", mem[8'hE1], 32'hDEAD_0081);
    check("R4 second desc", mem[8'hF0], 32'hDEAD_0084);
    check("R10 write count", wr_count, 32'd3);
    check("R10 low memory untouched", mem[0], 32'hDEAD_0000);
    check("R4 status", {27'd0, status}, 32'h3);
  endtask

  task automatic t_array_err(input string tag, input logic [31:0] s,
                             input logic [31:0] d, input logic [31:0] c);
    prep();
    put_desc(32'h100, s, d, c);
    kick(32'h100);
    wait_idle();
    check({"R6 status ", tag}, {27'd0, status}, 32'h10);
    check({"R6 no irq ", tag}, {31'd0, irq}, 32'h0);
    check({"R6 no writes ", tag}, wr_count, 32'd0);
  endtask

  task automatic t_base_misalign();
    prep();
    kick(32'h102);
    repeat (4) @(negedge clk);
    check("R6 misaligned base", {27'd0, status}, 32'h10);
    check("R6 misaligned base busy", {31'd0, busy}, 32'h0);
  endtask

  task automatic t_fetch_err();
    prep();
    put_desc(32'h100, 32'h200, 32'h300, 32'h8000_0004);
    err_on = 1'b1; err_addr = 32'h104; err_we = 1'b0;
    kick(32'h100);
    wait_idle();
    check("R6 fetch error", {27'd0, status}, 32'h10);
    check("R6 fetch error writes", wr_count, 32'd0);
  endtask

  task automatic t_rd_err();
    prep();
    put_desc(32'h100, 32'h200, 32'h300, 32'h8000_000C);
    err_on = 1'b1; err_addr = 32'h204; err_we = 1'b0;
    kick(32'h100);
    wait_idle();
    check("R7 status", {27'd0, status}, 32'h04);
    check("R7 writes before error", wr_count, 32'd1);
    check("R7 word not written", mem[8'hC1], 32'hDEAD_00C1);
  endtask

  task automatic t_wr_err();
    prep();
    put_desc(32'h100, 32'h200, 32'h300, 32'h8000_0004);
    err_on = 1'b1; err_addr = 32'h300; err_we = 1'b1;
    kick(32'h100);
    wait_idle();
    check("R8 status", {27'd0, status}, 32'h09);
    check("R8 no irq", {31'd0, irq}, 32'h0);
  endtask

  task automatic t_collide();
    int seen_done;
    int seen_irq;
    prep();
    seen_done = 0;
    seen_irq = 0;
    put_desc(32'h100, 32'h200, 32'h300, 32'h8000_0004);
    @(negedge clk); clr = 1'b1; clr_mask = 5'h1F;
    kick(32'h100);
    for (int i = 0; i < 40; i++) begin
      if (status[1]) seen_done++;
      if (irq) seen_irq++;
      @(negedge clk);
    end
    clr = 1'b0; clr_mask = 5'h00;
    check("R9 set wins: done cycles", seen_done, 32'd1);
    check("R9 set wins: irq cycles", seen_irq, 32'd1);
    check("R9 cleared after", {27'd0, status}, 32'h0);
    check("R3 copy under clear", mem[8'hC0], 32'hDEAD_0080);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_chain();
    t_array_err("zero len", 32'h200, 32'h300, 32'h8000_0000);
    t_array_err("src align", 32'h202, 32'h300, 32'h8000_0004);
    t_array_err("dst align", 32'h200, 32'h301, 32'h8000_0004);
    t_array_err("len align", 32'h200, 32'h300, 32'h8000_0006);
    t_base_misalign();
    t_fetch_err();
    t_rd_err();
    t_wr_err();
    t_collide();
    finish_run();
  end

endmodule